// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (SCL and SDA, SMBus style). It gives a host controller read and write access to a bank of 8-bit control registers that the rest of the chip uses as static configuration. Both bus lines are sampled with the system clock. The slave pulls SDA low through an open-drain enable and never drives it high. After reset every register holds its default value, so the chip runs correctly even if the host never uses the bus.

After the device address, the host sends a command byte. When bit 7 of the command is set, the access is a single indexed one: bits 6:0 give the register offset. A byte write sends one data byte. A byte read uses a repeated START, then the read form of the address, and then returns one data byte. When bit 7 is clear, the access is a block transfer that always begins at register 0 and walks upward:

- A block write sends a count byte and then data bytes.
- A block read returns a count byte (the bank depth) and then the registers in order.

The host may end either kind of transfer after any complete byte.

The register contents are presented as one flat vector for the logic that consumes them.

Top module: `tw_reg_slave`

## Requirements
- R1: The slave ACKs only the address bytes 0xD2 (write form) and 0xD3 (read form). Any other address is NACKed, and the slave ignores the bus until the next START or STOP.
- R2: A command byte with bit 7 = 1 selects single access at the offset in bits 6:0. One data byte that follows it is written to that register, and a following read returns that register.
- R3: A command byte with bit 7 = 0 selects a block write. The next byte is a count; it is ACKed and its value is ignored. The data bytes after it are written to registers 0, 1, 2, ... in arrival order.
- R4: A read-form address that follows a block command returns first the byte 32 (the bank depth) and then registers 0, 1, 2, ... in order.
- R5: Every byte on the bus is transferred most significant bit first, both inbound and outbound.
- R6: A STOP after any complete data byte keeps every byte completed before it. A byte cut short by STOP is not written.
- R7: After reset, each of the 32 registers holds 0x5A, and SDA is not driven.
- R8: Offsets 32 to 127 are ACKed. Writes to them change no register, and reads of them return 0x00.
- R9: During a read, the slave ACKs each address, command and written byte. When the master NACKs a read byte, the slave stops sending and leaves SDA released until the next START.
- R10: The slave only pulls SDA low. It changes its SDA drive only while SCL is low, apart from resetting on START or STOP.
- R11: A START or repeated START restarts address reception at any point. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 256 | Register bank, register i at bits 8*i+7 : 8*i |

## Verification
The bench targets these corner cases:

- **Block write cut short.** The host sends a count larger than the number of bytes it then delivers. A design that waited for the count would drop the bytes already delivered.
- **Byte cut short.** A STOP arrives in the middle of a data byte. A design that committed partial bytes would corrupt the register.
- **Offsets past the bank.** A design that wrapped the offset would overwrite a low register, or would return stale data instead of zero.
- **Block read header.** The count byte must lead and the data must restart at register 0. An off-by-one pointer shows up as shifted data.
- **Foreign address.** This checks that a non-matching address gets no ACK.

Constrained random single and block transfers with a fixed seed then exercise the bit ordering and the pointer stepping against a bench model of the bank.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Protocol sequencer states
  typedef enum logic [3:0] {
    ST_IDLE,  // bus free, waiting for START
    ST_ADDR,  // receiving address byte
    ST_CMD,   // receiving command byte
    ST_CNT,   // receiving block count byte
    ST_WDAT,  // receiving write data byte
    ST_ACK,   // slave holding SDA low for one SCL pulse
    ST_RDAT,  // shifting a read byte out
    ST_RACK,  // sampling the master acknowledge
    ST_WAIT   // not addressed, waiting for START or STOP
  } tw_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  // two-stage synchronizers plus one history stage, idle-high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_o      = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA moving while SCL stays high marks bus conditions
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int unsigned DEPTH   = 32,
  parameter logic [7:0]  RST_VAL = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [6:0]         waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [6:0]         raddr_i,
  output logic [7:0]         rdata_o,
  output logic [DEPTH*8-1:0] regs_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic hit;
    assign hit = we_i && (waddr_i == 7'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= RST_VAL;
      else if (hit) mem[i] <= wdata_i;
    end
    assign regs_o[i*8 +: 8] = mem[i];
  end

  // offsets beyond the bank read as zero
  assign rdata_o = ({1'b0, raddr_i} < 8'(DEPTH)) ? mem[raddr_i[AW-1:0]] : 8'h00;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int unsigned DEPTH    = 32,
  parameter logic [7:0]  RST_VAL  = 8'h5A,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [DEPTH*8-1:0] regs_o
);
  import tw_pkg::*;

  localparam logic [7:0] CNT_BYTE = 8'(DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  tw_bus_sync i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  tw_state_e  state_q, state_d, after_q, after_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d;
  logic [6:0] ptr_q, ptr_d;
  logic       blk_q, blk_d, cnt_q, cnt_d, mack_q, mack_d;
  logic       we;
  logic [7:0] rd_data;

  tw_regfile #(.DEPTH(DEPTH), .RST_VAL(RST_VAL)) i_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr_q), .wdata_i(sh_q),
    .raddr_i(ptr_q), .rdata_o(rd_data), .regs_o(regs_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q; after_d = after_q; bit_d = bit_q; sh_d = sh_q;
    tx_d = tx_q; ptr_d = ptr_q; blk_d = blk_q; cnt_d = cnt_q; mack_d = mack_q;
    we = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
    end else if (start) begin
      state_d = ST_ADDR;
      bit_d   = 4'd0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = 4'(bit_q + 4'd1);
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d   = 4'd0;
            state_d = ST_ACK;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                after_d = sh_q[0] ? ST_RDAT : ST_CMD;
                if (sh_q[0]) begin
                  cnt_d = blk_q;
                  if (blk_q) ptr_d = 7'd0;
                end
              end else begin
                state_d = ST_WAIT;
              end
            end else if (state_q == ST_CMD) begin
              blk_d   = ~sh_q[7];
              ptr_d   = sh_q[7] ? sh_q[6:0] : 7'd0;
              after_d = sh_q[7] ? ST_WDAT : ST_CNT;
            end else if (state_q == ST_CNT) begin
              after_d = ST_WDAT;
            end else begin
              we      = 1'b1;
              ptr_d   = 7'(ptr_q + 7'd1);
              after_d = ST_WDAT;
            end
          end
        end
        ST_ACK, ST_RACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            bit_d = 4'd0;
            if (state_q == ST_ACK) state_d = after_q;
            else                   state_d = mack_q ? ST_RDAT : ST_WAIT;
            if ((state_q == ST_ACK && after_q == ST_RDAT) || (state_q == ST_RACK && mack_q)) begin
              tx_d  = cnt_q ? CNT_BYTE : rd_data;
              if (!cnt_q) ptr_d = 7'(ptr_q + 7'd1);
              cnt_d = 1'b0;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_d = 4'(bit_q + 4'd1);
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              state_d = ST_RACK;
              bit_d   = 4'd0;
            end else begin
              tx_d = {tx_q[6:0], 1'b1};
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; after_q <= ST_IDLE; bit_q <= 4'd0; sh_q <= 8'd0;
      tx_q <= 8'hFF; ptr_q <= 7'd0; blk_q <= 1'b0; cnt_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      state_q <= state_d; after_q <= after_d; bit_q <= bit_d; sh_q <= sh_d;
      tx_q <= tx_d; ptr_q <= ptr_d; blk_q <= blk_d; cnt_q <= cnt_d; mack_q <= mack_d;
    end
  end

  assign sda_oe_o = (state_q == ST_ACK) || (state_q == ST_RDAT && !tx_q[7]);
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int unsigned DEPTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic               scl_s,
  input logic               start,
  input logic               stop,
  input tw_pkg::tw_state_e  state_q,
  input logic [3:0]         bit_q,
  input logic               we,
  input logic [6:0]         waddr,
  input logic [DEPTH*8-1:0] regs
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start) && !$past(stop)) |-> $stable(sda_oe));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state_q == tw_pkg::ST_IDLE) && !sda_oe);

  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'd8);

  // R8
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ({1'b0, waddr} >= 8'(DEPTH))) |=> $stable(regs));

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s),
  .start(start), .stop(stop), .state_q(state_q), .bit_q(bit_q),
  .we(we), .waddr(ptr_q), .regs(regs_o)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int DEPTH = 32;
  localparam int Q     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [DEPTH*8-1:0] regs;
  wire  sda = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  tw_reg_slave i_tw_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int off);
    return (off < DEPTH) ? model[off] : 8'h00;
  endfunction

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); ack = ~sda; hold(); scl = 1'b0; hold();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl = 1'b1; hold(); b[i] = sda; hold(); scl = 1'b0;
    end
    sda_m = ~mack; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic regs_match(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      if (regs[i*8 +: 8] !== model[i]) begin
        chk(tag, {24'd0, regs[i*8 +: 8]}, {24'd0, model[i]});
        return;
      end
    end
    chk(tag, 1, 1);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); wbyte(8'hD2, a0); wbyte(8'h80 | 8'(off), a1); wbyte(d, a2); bus_stop();
    chk("R2 byte write acks", {a0, a1, a2}, 3'b111);
    if (off < DEPTH) model[off] = d;
    regs_match(off < DEPTH ? "R2 byte write regs" : "R8 oob write regs");
  endtask

  task automatic byte_read(input int off);
    logic a0, a1, a2; logic [7:0] d;
    bus_start(); wbyte(8'hD2, a0); wbyte(8'h80 | 8'(off), a1);
    bus_start(); wbyte(8'hD3, a2); rbyte(1'b0, d);
    chk("R9 released after master NACK", sda_oe, 0);
    bus_stop();
    chk("R1 byte read acks", {a0, a1, a2}, 3'b111);
    chk(off < DEPTH ? "R2 byte read data" : "R8 oob read zero", d, exp_rd(off));
  endtask

  task automatic block_write(input int n, input int cnt);
    logic a; logic [7:0] d;
    bus_start(); wbyte(8'hD2, a); chk("R1 block write addr ack", a, 1);
    wbyte(8'h00, a); wbyte(8'(cnt), a); chk("R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, a); chk("R3 block data ack", a, 1);
      model[i] = d;
    end
    bus_stop();
    regs_match("R6 block write regs");
  endtask

  task automatic block_read(input int n);
    logic a; logic [7:0] d;
    bus_start(); wbyte(8'hD2, a); wbyte(8'h00, a);
    bus_start(); wbyte(8'hD3, a); chk("R1 read addr ack", a, 1);
    rbyte(1'b1, d); chk("R4 count byte", d, DEPTH);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk("R4 block read data", d, model[i]);
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h5A;
    void'($urandom(32'h1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R7 reset state
    regs_match("R7 reset defaults");
    chk("R7 sda released", sda_oe, 0);
    // R1 foreign address
    bus_start(); wbyte(8'hA4, a); chk("R1 foreign address NACK", a, 0);
    wbyte(8'h85, a); chk("R1 ignored after NACK", a, 0); bus_stop();
    regs_match("R1 foreign no change");
    // R2 / R5 asymmetric pattern
    byte_write(5, 8'h01); byte_read(5);
    byte_write(31, 8'h80); byte_read(31);
    // R8 out of range
    byte_write(40, 8'hEE); byte_read(40); byte_read(127);
    // R3 / R6 block write cut short
    block_write(4, 4); block_write(3, 10);
    block_read(6);
    // R6 / R11 byte cut by STOP
    bus_start(); wbyte(8'hD2, a); wbyte(8'h87, a); send_bits(8'h00, 4);
    scl = 1'b0; bus_stop();
    regs_match("R6 partial byte dropped");
    // R11 repeated START mid-command restarts address phase
    bus_start(); wbyte(8'hD2, a); send_bits(8'h80, 3);
    byte_write(9, 8'hC3); byte_read(9);
    // random mix
    for (int it = 0; it < 24; it++) begin
      int op, off, n;
      op = int'($urandom_range(0, 3));
      off = int'($urandom_range(0, 39));
      n = int'($urandom_range(1, 8));
      case (op)
        0: byte_write(off, 8'($urandom));
        1: byte_read(off);
        2: block_write(n, int'($urandom_range(1, 32)));
        default: block_read(n);
      endcase
    end
    block_read(DEPTH);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule